// File: doc/BRIEF.md
# Buffered Serial Transmitter with Holding-Register-Empty Interrupt

This block is the transmit half of a byte-wide serial port register set. Software writes characters into a holding register. They queue in a 16-character FIFO, and a serializer state machine drains the FIFO one frame at a time onto the `txd` line. Software learns that it may refill the queue from two sources: an empty bit in the line status register, and a holding-empty interrupt reported through the identification register. After that interrupt, software may write up to 16 characters. The block offers no full indication, so software must count its writes itself.

The interrupt becomes pending on the clock edge where the last queued character moves into the serializer. It clears on any write to the holding register. It also clears on a read of the identification register, but only when that read actually reported it. A single `line_irq` input stands in for a higher-priority source and takes precedence in the identification code.

The serializer states are IDLE, START, DATA and STOP:
- IDLE goes to START when the FIFO is not empty, and the character is popped on that same edge.
- START goes to DATA after one bit period.
- DATA goes to STOP after the eighth bit period.
- STOP goes to IDLE after one bit period.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset the block shows the following: `txd` is 1, `irq` is 0, `drop_seen` is 0, the identification register (offset 2) reads 0x01, and the line status register (offset 5) reads 0x60.
- R2: A write to offset 0 queues `reg_wdata`. Reads of offsets 2 and 5 return the identification and line status values. Reads have side effects only at offset 2.
- R3: The FIFO holds 16 characters. A write that arrives while 16 are held is discarded and sets `drop_seen`, which stays set until reset. When the line is idle, the serializer takes the first character on the edge after it is written, so 17 back-to-back writes are all kept.
- R4: Line status bit 5 is 1 exactly when the FIFO is empty. Bit 6 is 1 when the FIFO is empty and the serializer is in IDLE. All other bits read 0, so a full FIFO reads 0x00.
- R5: On the edge where the last FIFO entry enters the serializer, the holding-empty interrupt becomes pending. `irq` then goes to 1 and the identification register reads 0x02.
- R6: Any write to offset 0 clears the pending holding-empty interrupt on that edge.
- R7: A read strobe at offset 2 clears the holding-empty interrupt only when that read returned 0x02. A read that returned another code leaves it pending.
- R8: While `line_irq` is 1, the identification register reads 0x06 and `irq` is 1, whatever the holding-empty state.
- R9: Each frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit, each lasting `BIT_CLKS` clocks. The line idles at 1.
- R10: Characters leave on `txd` in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_irq | input | 1 | Higher-priority interrupt stub |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |
| drop_seen | output | 1 | Sticky flag: a write was discarded |

## Verification
Each kind of wrong internal state shows at the ports in its own way.
- A FIFO pointer or count error shows on `txd` within one frame, as a character that is repeated, missing or out of order. The scoreboard compares every frame against the queue of accepted writes.
- A wrong interrupt-pending bit shows on `irq` and in the identification code on the next sample after the edge that should have set or cleared it. This includes an early set while characters remain, or a clear by a read that reported the line code.
- A serializer state error shows as a wrong start, data or stop level at the mid-bit sample points.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    localparam logic [2:0] OFS_THR = 3'd0;
    localparam logic [2:0] OFS_IIR = 3'd2;
    localparam logic [2:0] OFS_LSR = 3'd5;
    localparam logic [7:0] IIR_NONE = 8'h01;
    localparam logic [7:0] IIR_THRE = 8'h02;
    localparam logic [7:0] IIR_LINE = 8'h06;
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         going_empty,
    output logic         drop_seen
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;
    logic          full, push_ok, pop_ok;

    assign full        = (count == (AW+1)'(DEPTH));
    assign empty       = (count == '0);
    assign push_ok     = push && !full;
    assign pop_ok      = pop && !empty;
    assign going_empty = pop_ok && !push_ok && (count == (AW+1)'(1));
    assign rdata       = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp        <= '0;
            rp        <= '0;
            count     <= '0;
            drop_seen <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            count <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
            if (push && full) drop_seen <= 1'b1;
        end
    end

    assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (drop_seen && $stable(wp)));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/utx_ser.sv
module utx_ser
    import utx_pkg::*;
#(
    parameter int BIT_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    tx_state_t state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          last_tick;

    assign last_tick = (cnt == CW'(BIT_CLKS-1));

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (!fifo_empty) nxt = TX_START;
            TX_START: if (last_tick) nxt = TX_DATA;
            TX_DATA:  if (last_tick && bit_idx == 3'd7) nxt = TX_STOP;
            TX_STOP:  if (last_tick) nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == TX_IDLE || last_tick) ? '0 : cnt + 1'b1;
            if (state == TX_IDLE && !fifo_empty) shreg <= fifo_data;
            if (state == TX_START) bit_idx <= '0;
            if (state == TX_DATA && last_tick) begin
                shreg   <= {1'b0, shreg[7:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        pop  = 1'b0;
        txd  = 1'b1;
        busy = 1'b1;
        unique case (state)
            TX_IDLE:  begin pop = !fifo_empty; busy = 1'b0; end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/utx_irq.sv
module utx_irq
    import utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       going_empty,
    input  logic       thr_wr,
    input  logic       iir_rd,
    input  logic       line_irq,
    input  logic       fifo_empty,
    output logic [7:0] iir,
    output logic       irq
);
    logic pend, rd_clr;

    assign rd_clr = iir_rd && !line_irq && pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (going_empty)       pend <= 1'b1;
        else if (thr_wr || rd_clr)  pend <= 1'b0;
    end

    always_comb begin
        if (line_irq)  iir = IIR_LINE;
        else if (pend) iir = IIR_THRE;
        else           iir = IIR_NONE;
        irq = line_irq || pend;
    end

    assert_rise_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> fifo_empty);
    assert_clear_cause_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> ($past(thr_wr) || ($past(iir_rd) && !$past(line_irq))));
    assert_line_keeps_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && line_irq && !thr_wr) |=> pend);
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
    import utx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int BIT_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       line_irq,
    output logic       txd,
    output logic       irq,
    output logic       drop_seen
);
    logic       thr_wr, iir_rd, pop, fifo_empty, going_empty, ser_busy;
    logic [7:0] fifo_data, iir;

    assign thr_wr = reg_wr && (reg_addr == OFS_THR);
    assign iir_rd = reg_rd && (reg_addr == OFS_IIR);

    utx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(thr_wr), .wdata(reg_wdata),
        .pop(pop), .rdata(fifo_data), .empty(fifo_empty),
        .going_empty(going_empty), .drop_seen(drop_seen)
    );

    utx_ser #(.BIT_CLKS(BIT_CLKS)) u_ser (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .pop(pop), .txd(txd), .busy(ser_busy)
    );

    utx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .going_empty(going_empty), .thr_wr(thr_wr),
        .iir_rd(iir_rd), .line_irq(line_irq), .fifo_empty(fifo_empty),
        .iir(iir), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_IIR: reg_rdata = iir;
            OFS_LSR: reg_rdata = {1'b0, fifo_empty && !ser_busy, fifo_empty, 5'b0};
            default: reg_rdata = 8'h00;
        endcase
    end

    assert_start_from_queue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_busy) |-> $past(!fifo_empty));
    assert_idle_line_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_busy |-> txd);
endmodule

// File: tb/uart_tx_buffered_test.sv
module uart_tx_buffered_test;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, line_irq = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       txd, irq, drop_seen;

    int n_tests = 0, n_fail = 0, n_rx = 0, n_sent = 0;
    bit finished = 0;
    logic [7:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_buffered #(.DEPTH(16), .BIT_CLKS(BIT_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_irq(line_irq), .txd(txd), .irq(irq), .drop_seen(drop_seen)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr_thr(input logic [7:0] d, input bit exp_drop);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = d; reg_wr = 1'b1;
        if (!exp_drop) begin sb_q.push_back(d); n_sent++; end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_iir(output logic [7:0] v);
        @(negedge clk);
        reg_addr = 3'd2; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    endtask

    task automatic wait_lsr(input logic [7:0] want, input int limit);
        logic [7:0] v;
        for (int i = 0; i < limit; i++) begin
            peek(3'd5, v);
            if (v == want) break;
            @(negedge clk);
        end
    endtask

    // Monitor: decodes frames at mid-bit and compares them against the scoreboard
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                repeat (BIT_CLKS/2) @(negedge clk);
                chk({7'd0, txd}, 8'h00, "R9 start bit");
                for (int b = 0; b < 8; b++) begin
                    repeat (BIT_CLKS) @(negedge clk);
                    got[b] = txd;
                end
                repeat (BIT_CLKS) @(negedge clk);
                chk({7'd0, txd}, 8'h01, "R9 stop bit");
                n_rx++;
                if (sb_q.size() == 0) chk(got, 8'hxx, "R10 unexpected frame");
                else chk(got, sb_q.pop_front(), "R9/R10 frame data in order");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("[TB] FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({7'd0, txd}, 8'h01, "R1 txd idle");
        chk({7'd0, irq}, 8'h00, "R1 irq");
        chk({7'd0, drop_seen}, 8'h00, "R1 drop_seen");
        peek(3'd2, v); chk(v, 8'h01, "R1 IIR");
        peek(3'd5, v); chk(v, 8'h60, "R1 LSR");
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: write queues a character, empty bit drops
        wr_thr(8'hA5, 0);
        peek(3'd5, v); chk(v, 8'h00, "R4 LSR with one queued");
        @(negedge clk);
        // R5: last entry moved to serializer
        chk({7'd0, irq}, 8'h01, "R5 irq set on going empty");
        peek(3'd2, v); chk(v, 8'h02, "R5 IIR holding-empty code");
        peek(3'd5, v); chk(v, 8'h20, "R4 FIFO empty, serializer busy");

        // R6: write clears pending
        wr_thr(8'h3C, 0);
        chk({7'd0, irq}, 8'h00, "R6 write clears interrupt");

        wait_irq(400);
        chk({7'd0, irq}, 8'h01, "R5 second going-empty");
        // R8 priority stub
        @(negedge clk); line_irq = 1'b1;
        peek(3'd2, v); chk(v, 8'h06, "R8 line code has priority");
        rd_iir(v); chk(v, 8'h06, "R7 read returned line code");
        line_irq = 1'b0;
        #1 peek(3'd2, v); chk(v, 8'h02, "R7 pending kept after line-code read");
        rd_iir(v); chk(v, 8'h02, "R7 read returns holding-empty");
        chk({7'd0, irq}, 8'h00, "R7 read clears interrupt");
        peek(3'd2, v); chk(v, 8'h01, "R7 IIR none after clear");

        wait_lsr(8'h60, 400);
        peek(3'd5, v); chk(v, 8'h60, "R4 fully idle");

        // Data patterns
        wr_thr(8'h00, 0); wr_thr(8'hFF, 0); wr_thr(8'h81, 0); wr_thr(8'h5A, 0);
        wait_lsr(8'h60, 1000);

        // R3: 17 accepted, 18th dropped
        chk({7'd0, drop_seen}, 8'h00, "R3 no drop yet");
        for (int i = 0; i < 17; i++) wr_thr(8'h10 + 8'(i), 0);
        peek(3'd5, v); chk(v, 8'h00, "R4 full FIFO has no full bit");
        chk({7'd0, drop_seen}, 8'h00, "R3 17 writes all kept");
        wr_thr(8'hEE, 1);
        chk({7'd0, drop_seen}, 8'h01, "R3 drop on full");
        wait_irq(5000);
        chk({7'd0, irq}, 8'h01, "R5 set after draining");
        peek(3'd5, v); chk(v, 8'h20, "R4 last frame still on line");
        wait_lsr(8'h60, 1000);
        repeat (4) @(negedge clk);
        chk(8'(sb_q.size()), 8'h00, "R10 scoreboard drained");
        chk(8'(n_rx), 8'(n_sent), "R10 frame count");
        chk({7'd0, drop_seen}, 8'h01, "R3 drop flag sticky");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule